// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the fetch address for a small processor with 12-bit instruction words and 2048 words of program memory. Every clock edge is one instruction cycle. An 11-bit address register normally steps by one; it is reloaded when the executing instruction is a jump, a call, a return, or a write to the low byte of the address. A two-level return stack holds call return addresses.

Program space is split into four 512-word pages. Jump targets supply nine address bits from the instruction word. Calls and low-byte writes supply only eight bits and clear bit 8. In every one of these loads, the top two bits come from two page-select bits held elsewhere in a status register. A return restores the full 11-bit address from the stack, whatever the page-select bits hold.

Whenever the address is loaded out of sequence, a flush pulse tells the fetch stage to replace the instruction it already fetched with a no-op, so a taken branch costs two cycles. The low byte of the current address is also exposed, so it can be read back as an ordinary data register.

Top module: `pc_seq`

## Requirements
- R1: While reset is held low, and after reset is released, the address reads 7FFh, the flush output is low and the low-byte output reads FFh, until the first clock edge after release.
- R2: On a sequential cycle the address becomes the previous address plus one, modulo 2048. The increment carries across page boundaries (1FFh to 200h) and wraps from 7FFh to 000h, and the page-select input has no effect.
- R3: On a jump the address becomes {page_i[1:0], imm_i[8:0]}.
- R4: On a call the address becomes {page_i[1:0], 1'b0, imm_i[7:0]}. On a low-byte write it becomes {page_i[1:0], 1'b0, wdata_i[7:0]}. In both cases imm_i[8] has no effect.
- R5: A call moves stack level 1 into level 2 and places the address of the calling instruction plus one into level 1. After three nested calls, only the two most recent return addresses remain.
- R6: A return loads the full 11-bit address from stack level 1 and moves level 2 into level 1. Further returns keep yielding the level-2 value, and page_i has no effect on a return.
- R7: flush_o is high during exactly the cycle that follows a jump, call, return or low-byte write, and is low after any sequential cycle.
- R8: pcl_o always equals bits 7:0 of pc_o.
- R9: op_i encodes the cycle class as follows: 0 sequential, 1 jump, 2 call, 3 return, 4 low-byte write. Codes 5 to 7 behave as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Class of the executing instruction |
| imm_i | input | 9 | Immediate address field of the instruction word |
| wdata_i | input | 8 | Data byte written to the address low byte |
| page_i | input | 2 | Page-select bits from the status register |
| pc_o | output | 11 | Current fetch address |
| flush_o | output | 1 | Discard the already-fetched instruction |
| pcl_o | output | 8 | Readable low byte of the address |

## Verification
A wrong page merge or a wrong bit-8 clearing appears on pc_o at the edge right after the jump, call or low-byte write. A stack that fails to shift shows up only later, at the first return that reaches the damaged level. The table therefore nests three calls and then issues three returns, so that a lost oldest entry or a missing bottom duplicate changes pc_o within three cycles. A flush that is delayed or stretched by one cycle is visible on the first sequential cycle after a load.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int unsigned PC_W   = 11;
  localparam int unsigned IMM_W  = 9;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SEQ  = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_LOWR = 3'd4
  } pc_op_e;
endpackage

// File: rtl/pc_stack.sv
module pc_stack #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0] lvl_q [DEPTH];
  logic [W-1:0] lvl_d [DEPTH];

  // push shifts toward the bottom (oldest falls off); pop shifts toward the
  // top while the bottom level keeps its value
  for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;
    if (k == 0) begin : g_top
      assign from_above = push_data_i;
    end else begin : g_mid
      assign from_above = lvl_q[k-1];
    end
    if (k == DEPTH-1) begin : g_bot
      assign from_below = lvl_q[k];
    end else begin : g_inner
      assign from_below = lvl_q[k+1];
    end
    assign lvl_d[k] = push_i ? from_above : (pop_i ? from_below : lvl_q[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= lvl_d[i];
    end
  end

  assign top_o = lvl_q[0];
endmodule

// File: rtl/pc_target.sv
module pc_target
  import pc_seq_pkg::*;
#(
  parameter int unsigned PCW  = PC_W,
  parameter int unsigned IMMW = IMM_W,
  parameter int unsigned BW   = BYTE_W
) (
  input  logic [OP_W-1:0]     op_i,
  input  logic [PCW-1:0]      pc_i,
  input  logic [IMMW-1:0]     imm_i,
  input  logic [BW-1:0]       wdata_i,
  input  logic [PCW-IMMW-1:0] page_i,
  input  logic [PCW-1:0]      ret_addr_i,
  output logic [PCW-1:0]      pc_inc_o,
  output logic [PCW-1:0]      pc_d_o,
  output logic                load_o
);
  localparam int unsigned GAP_W = IMMW - BW;

  pc_op_e op;
  assign op       = pc_op_e'(op_i);
  assign pc_inc_o = pc_i + {{(PCW-1){1'b0}}, 1'b1};

  always_comb begin
    pc_d_o = pc_inc_o;
    load_o = 1'b1;
    unique case (op)
      OP_JUMP: pc_d_o = {page_i, imm_i};
      OP_CALL: pc_d_o = {page_i, {GAP_W{1'b0}}, imm_i[BW-1:0]};
      OP_LOWR: pc_d_o = {page_i, {GAP_W{1'b0}}, wdata_i};
      OP_RET:  pc_d_o = ret_addr_i;
      default: load_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int unsigned STK_DEPTH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [OP_W-1:0]       op_i,
  input  logic [IMM_W-1:0]      imm_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic [PC_W-IMM_W-1:0] page_i,
  output logic [PC_W-1:0]       pc_o,
  output logic                  flush_o,
  output logic [BYTE_W-1:0]     pcl_o
);
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, ret_addr;
  logic            load, flush_q;

  pc_target u_target (
    .op_i      (op_i),
    .pc_i      (pc_q),
    .imm_i     (imm_i),
    .wdata_i   (wdata_i),
    .page_i    (page_i),
    .ret_addr_i(ret_addr),
    .pc_inc_o  (pc_inc),
    .pc_d_o    (pc_d),
    .load_o    (load)
  );

  pc_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (op_i == OP_CALL),
    .pop_i      (op_i == OP_RET),
    .push_data_i(pc_inc),
    .top_o      (ret_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '1;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      flush_q <= load;
    end
  end

  assign pc_o    = pc_q;
  assign flush_o = flush_q;
  assign pcl_o   = pc_q[BYTE_W-1:0];
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk
  import pc_seq_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [OP_W-1:0]       op_i,
  input logic [IMM_W-1:0]      imm_i,
  input logic [PC_W-IMM_W-1:0] page_i,
  input logic [PC_W-1:0]       pc_o,
  input logic                  flush_o
);
  logic is_load;
  assign is_load = (op_i == OP_JUMP) || (op_i == OP_CALL) ||
                   (op_i == OP_RET)  || (op_i == OP_LOWR);

  assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_load |=> pc_o == $past(pc_o) + 11'd1);

  assert_jump_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_JUMP |=> pc_o == {$past(page_i), $past(imm_i)});

  assert_call_bit8_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CALL || op_i == OP_LOWR) |=> pc_o[8] == 1'b0 && pc_o[10:9] == $past(page_i));

  assert_call_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CALL) ##1 (op_i == OP_RET) |=> pc_o == $past(pc_o, 2) + 11'd1);

  assert_flush_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_load |=> flush_o);

  assert_no_flush_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_load |=> !flush_o);
endmodule

bind pc_seq pc_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .op_i   (op_i),
  .imm_i  (imm_i),
  .page_i (page_i),
  .pc_o   (pc_o),
  .flush_o(flush_o)
);

// File: tb/pc_seq_bench.sv
module pc_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [8:0]  imm_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [1:0]  page_i = '0;
  logic [10:0] pc_o;
  logic        flush_o;
  logic [7:0]  pcl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pc_seq u_pc_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op_i),
    .imm_i  (imm_i),
    .wdata_i(wdata_i),
    .page_i (page_i),
    .pc_o   (pc_o),
    .flush_o(flush_o),
    .pcl_o  (pcl_o)
  );

  // {req, op, imm, wdata, page, expected pc, expected flush}
  localparam logic [37:0] VEC [NVEC] = '{
    {4'd2, 3'd0, 9'h000, 8'h00, 2'd0, 11'h000, 1'b0}, // R2 wrap 7FF->000
    {4'd3, 3'd1, 9'h1FF, 8'h00, 2'd0, 11'h1FF, 1'b1}, // R3
    {4'd2, 3'd0, 9'h000, 8'h00, 2'd3, 11'h200, 1'b0}, // R2 page cross
    {4'd3, 3'd1, 9'h0A5, 8'h00, 2'd3, 11'h6A5, 1'b1}, // R3
    {4'd4, 3'd2, 9'h1C3, 8'h00, 2'd1, 11'h2C3, 1'b1}, // R4 call, push 6A6
    {4'd7, 3'd0, 9'h000, 8'h00, 2'd0, 11'h2C4, 1'b0}, // R7
    {4'd5, 3'd2, 9'h012, 8'h00, 2'd2, 11'h412, 1'b1}, // R5 push 2C5
    {4'd5, 3'd2, 9'h077, 8'h00, 2'd0, 11'h077, 1'b1}, // R5 push 413, 6A6 lost
    {4'd6, 3'd3, 9'h000, 8'h00, 2'd0, 11'h413, 1'b1}, // R6
    {4'd5, 3'd3, 9'h000, 8'h00, 2'd0, 11'h2C5, 1'b1}, // R5
    {4'd6, 3'd3, 9'h000, 8'h00, 2'd0, 11'h2C5, 1'b1}, // R6 bottom duplicated
    {4'd4, 3'd4, 9'h1FF, 8'hEE, 2'd3, 11'h6EE, 1'b1}, // R4 low write
    {4'd8, 3'd0, 9'h000, 8'h00, 2'd0, 11'h6EF, 1'b0}, // R8
    {4'd4, 3'd2, 9'h1FF, 8'h00, 2'd3, 11'h6FF, 1'b1}, // R4 imm bit 8 ignored
    {4'd6, 3'd3, 9'h000, 8'h00, 2'd0, 11'h6F0, 1'b1}, // R6 page ignored
    {4'd9, 3'd5, 9'h1FF, 8'h33, 2'd2, 11'h6F1, 1'b0}, // R9 code 5
    {4'd9, 3'd7, 9'h0AA, 8'h55, 2'd1, 11'h6F2, 1'b0}, // R9 code 7
    {4'd7, 3'd0, 9'h000, 8'h00, 2'd0, 11'h6F3, 1'b0}  // R7
  };

  task automatic check(input int req, input logic [10:0] epc, input logic efl);
    n_chk++;
    if (pc_o !== epc || flush_o !== efl || pcl_o !== epc[7:0]) begin
      n_bad++;
      $display("FAIL R%0d: pc=%h flush=%b pcl=%h expected pc=%h flush=%b pcl=%h",
               req, pc_o, flush_o, pcl_o, epc, efl, epc[7:0]);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [8:0] imm,
                       input logic [7:0] wd, input logic [1:0] pg);
    op_i = op; imm_i = imm; wdata_i = wd; page_i = pg;
  endtask

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    check(1, 11'h7FF, 1'b0); // R1 during reset
    rst_ni = 1'b1;
    check(1, 11'h7FF, 1'b0); // R1 after release

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][33:31], VEC[i][30:22], VEC[i][21:14], VEC[i][13:12]);
      @(negedge clk_i);
      check(int'(VEC[i][37:34]), VEC[i][11:1], VEC[i][0]);
    end

    // r1_ asynchronous reset in mid-run
    drive(3'd1, 9'h055, 8'h00, 2'd2);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(1, 11'h7FF, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 jump to the top of the last page, then R2 wrap
    drive(3'd1, 9'h1FF, 8'h00, 2'd3);
    @(negedge clk_i);
    check(3, 11'h7FF, 1'b1);
    drive(3'd0, 9'h000, 8'h00, 2'd3);
    @(negedge clk_i);
    check(2, 11'h000, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule